// File: doc/BRIEF.md
# Asynchronous Memory and Peripheral Bus Controller

This controller turns 32-bit word requests from an on-chip master into cycles on an external bus with separate address and data lines. That bus serves SRAM, flash, ROM and simple peripherals. The bus has a 16-bit data path, a 26-bit byte address and six active-low chip selects. Each chip select covers a region of up to 64 MB. The upper six bits of the internal address pick the region through a base/mask compare. Each chip select has its own configuration word. The word sets the device width, the minimum wait states, an idle gap after each access, how the external wait pin is read, and write protection.

A word request can go to a device narrower than 32 bits. In that case the controller runs one external access for each enabled byte (8-bit device) or each enabled half-word (16-bit device), in increasing address order. On reads it merges the returned pieces into one word. The external wait pin passes through a two-flop synchronizer. The configuration decides whether the pin stretches the access (wait mode) or must be seen to end it (acknowledge mode). A per-access watchdog ends an access that never finishes and raises a warm-reset request.

The internal side uses a valid/ready handshake and carries one request at a time. Each request ends with a one-cycle done pulse. That pulse carries the read data and three error flags.

The sequencer has five states:
- IDLE: ready.
- CHECK: decode, protection and lane check.
- ACCESS: strobes active.
- HOLD: post-access gap.
- DONE: done pulse.

It has these transitions:
- IDLE to CHECK on accept.
- CHECK to DONE on a miss, a protected write or no enabled lanes.
- CHECK to ACCESS otherwise.
- ACCESS to HOLD when an access finishes and the gap is non-zero.
- ACCESS to ACCESS when the gap is zero and another piece remains.
- ACCESS to DONE on the last piece or on a timeout.
- HOLD to ACCESS or DONE when the gap ends.
- DONE to IDLE.

Top module: `mpbus_ctrl`

## Requirements
- R1: A request goes to the lowest-numbered chip select i for which ((addr[31:26] ^ base_i) & mask_i) == 0. Only that chip select's active-low line is driven low during its accesses, and at most one chip select line is ever low.
- R2: A request that matches no chip select produces done one cycle after the accept edge, with err_decode set and no chip select asserted.
- R3: For a 16-bit device (cfg bit 11 = 1), the controller runs one access for each half-word that has any enabled byte, lower half first. The external address equals addr[25:2] followed by the half index and a 0. ext_be_n is the inverted byte enables of that half. Write data is the matching half of the word.
- R4: For an 8-bit device (cfg bit 11 = 0), the controller runs one access for each enabled byte, in increasing lane order. Byte lane i goes to external address {addr[25:2], i} on data bits [7:0]. Read data is merged into lane i. Lanes whose byte enable is 0 read back as zero for either device width.
- R5: Each access keeps its strobe asserted for at least W+1 cycles, where W is cfg bits [5:0] (0 to 63).
- R6: After each access, all chip selects and strobes stay high for P cycles, where P is cfg bits [10:6] (0 to 31). With the wait pin inactive, a request with N pieces ends in done exactly 1 + N·(W+1+P) cycles after the accept edge.
- R7: In wait mode (cfg bit 12 = 0), an access does not end while the synchronized wait pin is high. The access ends in the third cycle after the pin goes low, once W is met.
- R8: In acknowledge mode (cfg bit 12 = 1), an access ends only once the synchronized pin is high and W is met.
- R9: A write to a chip select with cfg bit 13 set produces done one cycle after accept, with err_wprot set and no write strobe. Reads of that region work normally.
- R10: If one access lasts TMO_CYC cycles without ending, the request ends with done, err_timeout and warm_rst_req, all asserted together in that same cycle.
- R11: After reset, req_ready is high and every strobe and chip select is high. req_ready is high only in IDLE. done is a single-cycle pulse. A request with all byte enables zero ends one cycle after accept with no external access and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | INT_AW | Byte address; top six bits select the region |
| req_be_i | input | 4 | Byte enables of the word |
| req_wdata_i | input | 32 | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Merged read data, valid with done |
| err_decode_o | output | 1 | No chip select matched (with done) |
| err_wprot_o | output | 1 | Write rejected by protection (with done) |
| err_timeout_o | output | 1 | Access timed out (with done) |
| warm_rst_req_o | output | 1 | Warm-reset request on timeout |
| cs_base_i | input | NCS*6 | Region base per chip select |
| cs_mask_i | input | NCS*6 | Region compare mask per chip select |
| cs_cfg_i | input | NCS*14 | Per chip select: [5:0] wait states, [10:6] post gap, [11] 16-bit, [12] acknowledge mode, [13] write protect |
| ext_addr_o | output | EXT_AW | External byte address |
| ext_cs_n_o | output | NCS | Active-low chip selects |
| ext_rd_n_o | output | 1 | Active-low read strobe |
| ext_wr_n_o | output | 1 | Active-low write strobe |
| ext_be_n_o | output | 2 | Active-low byte lane enables |
| ext_data_o | output | EXT_DW | Write data to the bus |
| ext_data_oe_o | output | 1 | Write data drive enable |
| ext_data_i | input | EXT_DW | Read data from the bus |
| ext_wait_i | input | 1 | Wait / acknowledge pin (asynchronous) |

## Verification
The bench builds the controller with six chip selects and TMO_CYC = 100. A stuck wait or a missing acknowledge therefore trips the watchdog after a 101-cycle request, while the longest legal access still fits inside the window. That legal access has the full 63 wait states plus a 31-cycle gap, and it checks the exact latency formula of R6. The six chip selects carry different configurations, so one run covers:
- both device widths,
- both pin modes,
- a protected region,
- an overlapping base/mask pair for the priority rule,
- unmapped regions.

// File: rtl/mpbus_pkg.sv
package mpbus_pkg;

    // Per chip-select configuration word (14 bits).
    typedef struct packed {
        logic       wprot;     // [13] reject writes
        logic       ack_mode;  // [12] 1: pin is acknowledge, 0: pin is wait
        logic       wide16;    // [11] 1: 16-bit device, 0: 8-bit device
        logic [4:0] post;      // [10:6] idle gap after each access
        logic [5:0] wstates;   // [5:0] minimum wait states
    } cs_cfg_t;

    localparam int CFG_W = $bits(cs_cfg_t);
    localparam int LANES = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_ACCESS,
        S_HOLD,
        S_DONE
    } bus_state_t;

endpackage

// File: rtl/mpbus_sync2.sv
module mpbus_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            q      <= 1'b0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/mpbus_cs_decode.sv
module mpbus_cs_decode #(
    parameter int NCS  = 6,
    parameter int RW   = 6,
    parameter int IDXW = $clog2(NCS)
) (
    input  logic [RW-1:0]     region,
    input  logic [NCS*RW-1:0] base,
    input  logic [NCS*RW-1:0] mask,
    output logic              hit,
    output logic [IDXW-1:0]   idx
);
    logic [NCS-1:0] match;

    for (genvar g = 0; g < NCS; g++) begin : g_cmp
        assign match[g] = ((region ^ base[g*RW +: RW]) & mask[g*RW +: RW]) == '0;
    end

    // Scan from the top down so the lowest matching index is the last written.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NCS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/mpbus_watchdog.sv
module mpbus_watchdog #(
    parameter int LIMIT = 1024,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expire
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/mpbus_ctrl.sv
module mpbus_ctrl
    import mpbus_pkg::*;
#(
    parameter int NCS     = 6,
    parameter int TMO_CYC = 1024,
    parameter int INT_AW  = 32,
    parameter int EXT_AW  = 26,
    parameter int EXT_DW  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid_i,
    output logic                  req_ready_o,
    input  logic                  req_we_i,
    input  logic [INT_AW-1:0]     req_addr_i,
    input  logic [LANES-1:0]      req_be_i,
    input  logic [8*LANES-1:0]    req_wdata_i,
    output logic                  done_o,
    output logic [8*LANES-1:0]    rdata_o,
    output logic                  err_decode_o,
    output logic                  err_wprot_o,
    output logic                  err_timeout_o,
    output logic                  warm_rst_req_o,
    input  logic [NCS*(INT_AW-EXT_AW)-1:0] cs_base_i,
    input  logic [NCS*(INT_AW-EXT_AW)-1:0] cs_mask_i,
    input  logic [NCS*CFG_W-1:0]  cs_cfg_i,
    output logic [EXT_AW-1:0]     ext_addr_o,
    output logic [NCS-1:0]        ext_cs_n_o,
    output logic                  ext_rd_n_o,
    output logic                  ext_wr_n_o,
    output logic [1:0]            ext_be_n_o,
    output logic [EXT_DW-1:0]     ext_data_o,
    output logic                  ext_data_oe_o,
    input  logic [EXT_DW-1:0]     ext_data_i,
    input  logic                  ext_wait_i
);
    localparam int RW   = INT_AW - EXT_AW;
    localparam int IDXW = $clog2(NCS);
    localparam int WDW  = 8 * LANES;

    // Pieces to run: half-words for a 16-bit device, bytes for an 8-bit one.
    function automatic logic [LANES-1:0] piece_mask(input logic [LANES-1:0] be, input logic wide);
        return wide ? {2'b00, |be[3:2], |be[1:0]} : be;
    endfunction

    // First enabled piece at or above 'from'; bit 2 set means none left.
    function automatic logic [2:0] pick_piece(input logic [LANES-1:0] en, input logic [2:0] from);
        logic [2:0] r;
        r = 3'b100;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (k >= int'(from) && en[k]) r = 3'(k);
        end
        return r;
    endfunction

    bus_state_t state_q, state_d;

    logic              we_q;
    logic [INT_AW-1:0] addr_q;
    logic [LANES-1:0]  be_q;
    logic [WDW-1:0]    wdata_q;
    logic [WDW-1:0]    rbuf_q;
    cs_cfg_t           cfg_q;
    logic [IDXW-1:0]   csi_q;
    logic [1:0]        piece_q;
    logic              last_q;
    logic [5:0]        wcnt_q;
    logic [4:0]        pcnt_q;
    logic              e_dec_q, e_wp_q, e_tmo_q;

    logic              dec_hit;
    logic [IDXW-1:0]   dec_idx;
    cs_cfg_t           cfg_sel;
    logic [2:0]        first_pc, next_pc;
    logic              wait_s, acc_done, tmo_exp, chk_stop;
    logic [WDW-1:0]    lane_mask;

    mpbus_cs_decode #(.NCS(NCS), .RW(RW), .IDXW(IDXW)) u_dec (
        .region (addr_q[INT_AW-1 -: RW]),
        .base   (cs_base_i),
        .mask   (cs_mask_i),
        .hit    (dec_hit),
        .idx    (dec_idx)
    );

    mpbus_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_wait_i),
        .q     (wait_s)
    );

    mpbus_watchdog #(.LIMIT(TMO_CYC)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    ((state_q != S_ACCESS) || acc_done),
        .run    (state_q == S_ACCESS),
        .expire (tmo_exp)
    );

    assign cfg_sel  = cs_cfg_t'(cs_cfg_i[dec_idx*CFG_W +: CFG_W]);
    assign first_pc = pick_piece(piece_mask(be_q, cfg_sel.wide16), 3'd0);
    assign next_pc  = pick_piece(piece_mask(be_q, cfg_q.wide16), {1'b0, piece_q} + 3'd1);
    assign chk_stop = !dec_hit || (we_q && cfg_sel.wprot) || first_pc[2];
    assign acc_done = (wcnt_q >= cfg_q.wstates) && (cfg_q.ack_mode ? wait_s : !wait_s);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_mask[8*l +: 8] = {8{be_q[l]}};
    end

    // State and datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            we_q    <= 1'b0;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            rbuf_q  <= '0;
            cfg_q   <= '0;
            csi_q   <= '0;
            piece_q <= '0;
            last_q  <= 1'b0;
            wcnt_q  <= '0;
            pcnt_q  <= '0;
            e_dec_q <= 1'b0;
            e_wp_q  <= 1'b0;
            e_tmo_q <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: if (req_valid_i) begin
                    we_q    <= req_we_i;
                    addr_q  <= req_addr_i;
                    be_q    <= req_be_i;
                    wdata_q <= req_wdata_i;
                    rbuf_q  <= '0;
                    e_dec_q <= 1'b0;
                    e_wp_q  <= 1'b0;
                    e_tmo_q <= 1'b0;
                end
                S_CHECK: begin
                    cfg_q   <= cfg_sel;
                    csi_q   <= dec_idx;
                    piece_q <= first_pc[1:0];
                    wcnt_q  <= '0;
                    if (!dec_hit)                      e_dec_q <= 1'b1;
                    else if (we_q && cfg_sel.wprot)    e_wp_q  <= 1'b1;
                end
                S_ACCESS: begin
                    if (acc_done) begin
                        if (!we_q) begin
                            if (cfg_q.wide16) rbuf_q[EXT_DW*piece_q[0] +: EXT_DW] <= ext_data_i;
                            else              rbuf_q[8*piece_q +: 8]              <= ext_data_i[7:0];
                        end
                        piece_q <= next_pc[1:0];
                        last_q  <= next_pc[2];
                        wcnt_q  <= '0;
                        pcnt_q  <= '0;
                    end else if (tmo_exp) begin
                        e_tmo_q <= 1'b1;
                    end else if (wcnt_q != '1) begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                S_HOLD:  pcnt_q <= pcnt_q + 1'b1;
                S_DONE:  ;
                default: ;
            endcase
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid_i) state_d = S_CHECK;
            S_CHECK:  state_d = chk_stop ? S_DONE : S_ACCESS;
            S_ACCESS: begin
                if (acc_done) begin
                    if (cfg_q.post != '0) state_d = S_HOLD;
                    else                  state_d = next_pc[2] ? S_DONE : S_ACCESS;
                end else if (tmo_exp) begin
                    state_d = S_DONE;
                end
            end
            S_HOLD:   if (pcnt_q == cfg_q.post - 5'd1) state_d = last_q ? S_DONE : S_ACCESS;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        req_ready_o    = (state_q == S_IDLE);
        done_o         = (state_q == S_DONE);
        err_decode_o   = done_o && e_dec_q;
        err_wprot_o    = done_o && e_wp_q;
        err_timeout_o  = done_o && e_tmo_q;
        warm_rst_req_o = done_o && e_tmo_q;
        rdata_o        = rbuf_q & lane_mask;
        ext_cs_n_o     = '1;
        ext_rd_n_o     = 1'b1;
        ext_wr_n_o     = 1'b1;
        ext_data_oe_o  = 1'b0;
        ext_be_n_o     = 2'b11;
        ext_data_o     = '0;
        ext_addr_o     = '0;
        if (state_q == S_ACCESS) begin
            ext_cs_n_o[csi_q] = 1'b0;
            ext_rd_n_o        = we_q;
            ext_wr_n_o        = !we_q;
            ext_data_oe_o     = we_q;
            if (cfg_q.wide16) begin
                ext_addr_o = {addr_q[EXT_AW-1:2], piece_q[0], 1'b0};
                ext_be_n_o = ~be_q[2*piece_q[0] +: 2];
                ext_data_o = wdata_q[EXT_DW*piece_q[0] +: EXT_DW];
            end else begin
                ext_addr_o = {addr_q[EXT_AW-1:2], piece_q};
                ext_be_n_o = 2'b10;
                ext_data_o = {{(EXT_DW-8){1'b0}}, wdata_q[8*piece_q +: 8]};
            end
        end
    end
endmodule

// File: rtl/mpbus_ctrl_chk.sv
module mpbus_ctrl_chk #(
    parameter int NCS = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_ready_o,
    input logic           done_o,
    input logic           err_decode_o,
    input logic           err_wprot_o,
    input logic           err_timeout_o,
    input logic           warm_rst_req_o,
    input logic [NCS-1:0] ext_cs_n_o,
    input logic           ext_rd_n_o,
    input logic           ext_wr_n_o,
    input logic           ext_data_oe_o
);
    // R1: never more than one chip select active
    a_r1_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ext_cs_n_o) <= 1);

    // R1: a strobe is always accompanied by a chip select
    a_r1_strobe_has_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n_o || !ext_wr_n_o) |-> !(&ext_cs_n_o));

    // R2: a decode miss touches no chip select
    a_r2_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_decode_o) |-> ((&ext_cs_n_o) && $past(&ext_cs_n_o)));

    // R2: error flags appear only with done
    a_r2_flags_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (err_decode_o || err_wprot_o || err_timeout_o) |-> done_o);

    // R3: read and write strobes never overlap
    a_r3_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n_o && !ext_wr_n_o));

    // R9: data is driven only during a write strobe
    a_r9_oe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        ext_data_oe_o |-> !ext_wr_n_o);

    // R9: a rejected write finishes with all strobes idle
    a_r9_wp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        err_wprot_o |-> (ext_wr_n_o && $past(ext_wr_n_o)));

    // R10: warm reset request coincides with a timeout completion
    a_r10_warm_with_tmo: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_req_o |-> (done_o && err_timeout_o));

    // R11: done lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11: not ready while the bus is busy
    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n_o || !ext_wr_n_o || done_o) |-> !req_ready_o);
endmodule

bind mpbus_ctrl mpbus_ctrl_chk #(.NCS(NCS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_ready_o    (req_ready_o),
    .done_o         (done_o),
    .err_decode_o   (err_decode_o),
    .err_wprot_o    (err_wprot_o),
    .err_timeout_o  (err_timeout_o),
    .warm_rst_req_o (warm_rst_req_o),
    .ext_cs_n_o     (ext_cs_n_o),
    .ext_rd_n_o     (ext_rd_n_o),
    .ext_wr_n_o     (ext_wr_n_o),
    .ext_data_oe_o  (ext_data_oe_o)
);

// File: tb/mpbus_ctrl_tb.sv
module mpbus_ctrl_tb;
    localparam int NCS = 6;
    localparam int TMO = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_ready, done, e_dec, e_wp, e_tmo, warm;
    logic [31:0] rdata;
    logic [NCS*6-1:0]  cs_base, cs_mask;
    logic [NCS*14-1:0] cs_cfg;
    logic [25:0] ext_addr;
    logic [NCS-1:0] ext_cs_n;
    logic        ext_rd_n, ext_wr_n, ext_oe;
    logic [1:0]  ext_be_n;
    logic [15:0] ext_dout, ext_din;
    logic        wait_pin = 1'b0;

    always #2 clk = ~clk;

    mpbus_ctrl #(.NCS(NCS), .TMO_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
        .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
        .done_o(done), .rdata_o(rdata), .err_decode_o(e_dec), .err_wprot_o(e_wp),
        .err_timeout_o(e_tmo), .warm_rst_req_o(warm),
        .cs_base_i(cs_base), .cs_mask_i(cs_mask), .cs_cfg_i(cs_cfg),
        .ext_addr_o(ext_addr), .ext_cs_n_o(ext_cs_n), .ext_rd_n_o(ext_rd_n),
        .ext_wr_n_o(ext_wr_n), .ext_be_n_o(ext_be_n), .ext_data_o(ext_dout),
        .ext_data_oe_o(ext_oe), .ext_data_i(ext_din), .ext_wait_i(wait_pin)
    );

    // Chip-select setup: {wprot, ack, wide, post[4:0], wait[5:0]}
    logic [NCS-1:0] cs_wide;
    function automatic logic [13:0] mkcfg(input bit wp, input bit ack, input bit wide, input int p, input int w);
        return {wp, ack, wide, 5'(p), 6'(w)};
    endfunction

    initial begin
        cs_base = {6'd5, 6'd4, 6'd3, 6'd2, 6'd1, 6'd0};
        cs_mask = {6'h3F, 6'h3E, 6'h3F, 6'h3F, 6'h3F, 6'h3F};
        cs_cfg  = {mkcfg(0,0,0,0,0),  mkcfg(0,0,1,31,63), mkcfg(0,1,0,1,1),
                   mkcfg(1,0,1,0,1),  mkcfg(0,0,0,3,0),   mkcfg(0,0,1,0,2)};
        cs_wide = 6'b010101;
    end

    // Device model and bus monitor
    logic [7:0] mem [0:NCS*256-1];
    int cyc = 0, wr_cyc, pin_drop_at = -1;
    logic [5:0] cs_seen;
    logic [25:0] first_a, last_a;
    bit any_strobe, clr_mon = 1'b0;

    function automatic int act_cs(input logic [NCS-1:0] csn);
        int r = 0;
        for (int i = NCS - 1; i >= 0; i--) if (!csn[i]) r = i;
        return r;
    endfunction

    function automatic logic [7:0] pat(input int cs, input int off);
        return 8'((cs * 256 + off) ^ 32'h5A);
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCS * 256; i++) mem[i] <= pat(0, i);
        end else begin
            if (clr_mon) begin
                cs_seen <= '0; wr_cyc <= 0; any_strobe <= 1'b0;
            end else begin
                cs_seen <= cs_seen | ~ext_cs_n;
                if (!ext_rd_n || !ext_wr_n) begin
                    if (!any_strobe) first_a <= ext_addr;
                    last_a <= ext_addr;
                    any_strobe <= 1'b1;
                end
                if (!ext_wr_n) wr_cyc <= wr_cyc + 1;
            end
            if (!ext_wr_n && !(&ext_cs_n)) begin
                if (cs_wide[act_cs(ext_cs_n)]) begin
                    if (!ext_be_n[0]) mem[act_cs(ext_cs_n)*256 + {ext_addr[7:1], 1'b0}] <= ext_dout[7:0];
                    if (!ext_be_n[1]) mem[act_cs(ext_cs_n)*256 + {ext_addr[7:1], 1'b1}] <= ext_dout[15:8];
                end else begin
                    mem[act_cs(ext_cs_n)*256 + ext_addr[7:0]] <= ext_dout[7:0];
                end
            end
        end
    end

    always_comb begin
        ext_din = 16'h0;
        if (!(&ext_cs_n)) begin
            if (cs_wide[act_cs(ext_cs_n)])
                ext_din = {mem[act_cs(ext_cs_n)*256 + {ext_addr[7:1], 1'b1}],
                           mem[act_cs(ext_cs_n)*256 + {ext_addr[7:1], 1'b0}]};
            else
                ext_din = {8'h00, mem[act_cs(ext_cs_n)*256 + ext_addr[7:0]]};
        end
    end

    always @(posedge clk) begin
        #1;
        if (pin_drop_at >= 0 && cyc == pin_drop_at) wait_pin = 1'b0;
    end

    // Scoreboard
    typedef struct {
        logic [31:0] rdata;
        logic [2:0]  flags;
        int          lat;
        logic [5:0]  csm;
        string       req;
    } exp_t;
    exp_t exp_q[$];
    int n_tests = 0, n_fail = 0, resp_cnt = 0, acc_cyc = 0;
    bit finished = 1'b0;

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            if (exp_q.size() == 0) begin
                chk("R11", "unexpected done", 32'd1, 32'd0);
            end else begin
                e = exp_q.pop_front();
                chk(e.req, "rdata", rdata, e.rdata);
                chk(e.req, "flags dec/wp/tmo", {29'd0, e_dec, e_wp, e_tmo}, {29'd0, e.flags});
                chk(e.req, "warm reset req", {31'd0, warm}, {31'd0, e.flags[0]});
                chk(e.req, "latency", 32'(cyc - acc_cyc), 32'(e.lat));
                chk(e.req, "chip selects used", {26'd0, cs_seen}, {26'd0, e.csm});
            end
            resp_cnt++;
        end
    end

    task automatic run_req(input logic we, input logic [31:0] addr, input logic [3:0] be,
                           input logic [31:0] wd, input logic [31:0] erd, input logic [2:0] efl,
                           input int elat, input logic [5:0] ecs, input string rq);
        exp_t e;
        int n0;
        repeat (3) @(negedge clk);
        chk(rq, "ready before request", {31'd0, req_ready}, 32'd1);
        e.rdata = erd; e.flags = efl; e.lat = elat; e.csm = ecs; e.req = rq;
        exp_q.push_back(e);
        n0 = resp_cnt;
        req_valid = 1'b1; req_we = we; req_addr = addr; req_be = be; req_wdata = wd;
        clr_mon = 1'b1;
        @(posedge clk);
        #1;
        acc_cyc = cyc;
        req_valid = 1'b0;
        clr_mon = 1'b0;
        wait (resp_cnt != n0);
        @(negedge clk);
    endtask

    function automatic logic [31:0] ra(input int region, input int off);
        return {6'(region), 26'(off)};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "reset ready", {31'd0, req_ready}, 32'd1);
        chk("R11", "reset idle bus", {24'd0, ext_cs_n, ext_rd_n, ext_wr_n}, {24'd0, 6'h3F, 2'b11});
        chk("R11", "reset done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;

        // R3 R5: 16-bit full write then read, W=2 P=0 -> 1+2*3
        run_req(1, ra(0, 'h10), 4'hF, 32'hA1B2C3D4, 32'h0, 3'b000, 7, 6'b000001, "R3");
        run_req(0, ra(0, 'h10), 4'hF, 32'h0, 32'hA1B2C3D4, 3'b000, 7, 6'b000001, "R5");
        // R3: partial write touches only the upper half, one access
        run_req(1, ra(0, 'h14), 4'b0100, 32'h00EE0000, 32'h0, 3'b000, 4, 6'b000001, "R3");
        run_req(0, ra(0, 'h14), 4'hF, 32'h0, {pat(0, 'h17), 8'hEE, pat(0, 'h15), pat(0, 'h14)},
                3'b000, 7, 6'b000001, "R3");
        // R4: disabled lanes read zero on a 16-bit device
        run_req(0, ra(0, 'h14), 4'b0010, 32'h0, {16'h0, pat(0, 'h15), 8'h00}, 3'b000, 4, 6'b000001, "R4");

        // R4 R6: 8-bit device, W=0 P=3, four pieces -> 1+4*4
        run_req(1, ra(1, 'h20), 4'hF, 32'h44332211, 32'h0, 3'b000, 17, 6'b000010, "R6");
        chk("R4", "byte order first addr", {6'd0, first_a}, 32'h20);
        chk("R4", "byte order last addr", {6'd0, last_a}, 32'h23);
        chk("R4", "lane0 at lowest address", {24'd0, mem[256 + 'h20]}, 32'h11);
        chk("R4", "lane3 at highest address", {24'd0, mem[256 + 'h23]}, 32'h44);
        run_req(0, ra(1, 'h20), 4'hF, 32'h0, 32'h44332211, 3'b000, 17, 6'b000010, "R4");
        run_req(0, ra(1, 'h40), 4'b1010, 32'h0, {pat(1, 'h43), 8'h00, pat(1, 'h41), 8'h00},
                3'b000, 9, 6'b000010, "R4");
        chk("R4", "sparse first addr", {6'd0, first_a}, 32'h41);

        // R9: protected write rejected, region still readable and unchanged
        run_req(1, ra(2, 'h08), 4'hF, 32'hDEADBEEF, 32'h0, 3'b010, 1, 6'b000000, "R9");
        chk("R9", "no write strobe", 32'(wr_cyc), 32'd0);
        run_req(0, ra(2, 'h08), 4'hF, 32'h0, {pat(2, 'h0B), pat(2, 'h0A), pat(2, 'h09), pat(2, 'h08)},
                3'b000, 5, 6'b000100, "R9");

        // R2: unmapped region
        run_req(0, ra(8, 'h00), 4'hF, 32'h0, 32'h0, 3'b100, 1, 6'b000000, "R2");
        // R1: region 6 outside the cs4 mask pair -> miss
        run_req(1, ra(6, 'h00), 4'hF, 32'h1, 32'h0, 3'b100, 1, 6'b000000, "R1");

        // R8: acknowledge mode, ack held high -> 1+(2+1)
        wait_pin = 1'b1;
        run_req(0, ra(3, 'h30), 4'b0001, 32'h0, {24'h0, pat(3, 'h30)}, 3'b000, 4, 6'b001000, "R8");
        // R8 R10: no acknowledge -> timeout
        wait_pin = 1'b0;
        run_req(0, ra(3, 'h30), 4'b0001, 32'h0, 32'h0, 3'b001, 1 + TMO, 6'b001000, "R10");

        // R7 R10: wait mode, wait stuck high -> timeout
        wait_pin = 1'b1;
        run_req(0, ra(0, 'h10), 4'hF, 32'h0, 32'h0, 3'b001, 1 + TMO, 6'b000001, "R7");
        // R7: wait released 10 cycles after accept -> done at 10+3
        pin_drop_at = cyc + 4 + 10;
        run_req(0, ra(0, 'h10), 4'b0011, 32'h0, 32'h0000C3D4, 3'b000, 13, 6'b000001, "R7");
        pin_drop_at = -1;
        wait_pin = 1'b0;

        // R1 R5 R6: region 5 goes to cs4 (lower wins), W=63 P=31 -> 1+2*95
        run_req(0, ra(5, 'h60), 4'hF, 32'h0, {pat(4, 'h63), pat(4, 'h62), pat(4, 'h61), pat(4, 'h60)},
                3'b000, 191, 6'b010000, "R1");

        // R11: no byte enables -> no access, no error
        run_req(1, ra(0, 'h10), 4'h0, 32'hFFFFFFFF, 32'h0, 3'b000, 1, 6'b000000, "R11");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule